// File: doc/BRIEF.md
# Timing-Error Detecting Pipeline Register Bank

This block is a bank of pipeline registers placed between two combinational stages. It catches late-arriving data. Every bit is sampled twice. A main flop takes the value on the normal clock edge. A shadow flop takes the same input again on a second clock, which is phase-shifted later within the same cycle. If the two samples of a valid word differ, the main capture happened before the data had settled. The bank then raises an error in that same cycle, hides the word from the downstream stage and asks the upstream stage to hold. On the next edge it copies the shadow value into the main register. The operation therefore takes two cycles instead of one, and no corrupted word reaches the next stage marked valid.

The per-bit mismatches are OR-combined into one error flag. A saturating counter records how many errors have occurred, so the replay rate can be measured. In the cycle after an error, comparison is masked. Recovery therefore always lasts exactly one cycle, whatever the upstream stage presents while it is stalled.

Top module: `tmerr_reg_bank`

## Requirements
- R1: While reset is low and after its release with no valid input, out_valid, err_flag and stall_up are 0 and err_count is 0.
- R2: When stall_up is low at a clk edge, the bank captures in_data. If the late sample agrees, in the following cycle out_data equals the captured word and out_valid equals the in_valid seen at that edge.
- R3: If a valid captured word differs from the late sample in any bit position or set of positions, err_flag rises in that same cycle, after the late clock edge.
- R4: A mismatch on a word captured with in_valid low raises no error, leaves out_valid low and does not change err_count.
- R5: While err_flag is high, out_valid is 0 and stall_up is 1.
- R6: In the cycle after an error, out_data equals the late-sampled word, out_valid is 1 and err_flag is 0.
- R7: Data and valid presented on the input while stall_up is high are not captured; the restored word is presented instead.
- R8: err_flag is never high in two consecutive cycles, so each stall lasts exactly one cycle.
- R9: err_count increases by one on each error and saturates at 2^CNT_W-1. In the bench configuration (CNT_W=4) that is 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main capture clock, rising edge |
| clk_late | input | 1 | Same-frequency clock delayed within the cycle; drives the shadow samplers |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The word on in_data is a real operation |
| in_data | input | W | Output of the upstream combinational stage |
| stall_up | output | 1 | Upstream must hold; the current input is not taken this edge |
| out_valid | output | 1 | out_data carries a correct, valid word |
| out_data | output | W | Word presented to the downstream stage |
| err_flag | output | 1 | Timing error detected on the held word in this cycle |
| err_count | output | CNT_W | Saturating count of detected errors |

## Verification
The properties assume that clk_late rises after clk and before the next clk edge. They also assume that the data belonging to a capture has settled by the late edge and stays steady until it. The stimulus changes in_data in only two places in a cycle. One is shortly after the main edge and before the late edge, to model a late arrival. The other is after the late edge, to start the next operation. While stalled, the bench deliberately offers an unrelated valid word, so that the properties on restore and capture hold even with an upstream that does not hold its output.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic {
    ST_RUN     = 1'b0,
    ST_RECOVER = 1'b1
  } bank_state_e;

  // Saturating increment on a 32-bit carrier; callers cast to their width.
  function automatic logic [31:0] sat_step(input logic [31:0] cur,
                                           input logic [31:0] lim,
                                           input logic        hit);
    if (hit && (cur < lim)) return cur + 32'd1;
    return cur;
  endfunction

  // Largest value an n-bit counter holds (n <= 32).
  function automatic logic [31:0] max_of_width(input int unsigned n);
    logic [63:0] full;
    full = (64'd1 << n) - 64'd1;
    return full[31:0];
  endfunction

endpackage

// File: rtl/razor_cell.sv
module razor_cell (
  input  logic clk,
  input  logic clk_late,
  input  logic rst_n,
  input  logic d,
  input  logic load,
  input  logic restore,
  output logic main_q,
  output logic shadow_q,
  output logic mismatch
);

  // Main sampler: normal edge; the shadow value overrides on recovery.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       main_q <= 1'b0;
    else if (restore) main_q <= shadow_q;
    else if (load)    main_q <= d;
  end

  // Shadow sampler: same input, delayed edge.
  always_ff @(posedge clk_late or negedge rst_n) begin
    if (!rst_n) shadow_q <= 1'b0;
    else        shadow_q <= d;
  end

  assign mismatch = main_q ^ shadow_q;

endmodule

// File: rtl/razor_ctrl.sv
module razor_ctrl
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic any_mismatch,
  output logic err_now,
  output logic load,
  output logic restore,
  output logic main_valid,
  output logic out_valid
);

  bank_state_e state_q;
  logic        compare_en;

  // Comparison is masked in the recovery cycle: the shadow then holds the
  // next operation while the main register holds the restored one.
  assign compare_en = main_valid && (state_q == ST_RUN);
  assign err_now    = compare_en && any_mismatch;
  assign restore    = err_now;
  assign load       = !err_now;
  assign out_valid  = main_valid && !err_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RUN;
      main_valid <= 1'b0;
    end else begin
      state_q    <= err_now ? ST_RECOVER : ST_RUN;
      main_valid <= err_now ? 1'b1 : in_valid;
    end
  end

endmodule

// File: rtl/err_counter.sv
module err_counter
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  output logic [CNT_W-1:0] count
);

  localparam logic [31:0] LIM = max_of_width(CNT_W);

  logic [31:0] next_wide;

  assign next_wide = sat_step(32'(count), LIM, hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_wide[CNT_W-1:0];
  end

endmodule

// File: rtl/tmerr_reg_bank.sv
module tmerr_reg_bank #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             clk_late,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [W-1:0]     in_data,
  output logic             stall_up,
  output logic             out_valid,
  output logic [W-1:0]     out_data,
  output logic             err_flag,
  output logic [CNT_W-1:0] err_count
);

  logic [W-1:0] main_word;
  logic [W-1:0] shadow_word;
  logic [W-1:0] bit_mismatch;
  logic         any_mismatch;
  logic         err_now;
  logic         load;
  logic         restore;
  logic         main_valid;

  for (genvar b = 0; b < W; b++) begin : g_bit
    razor_cell u_cell (
      .clk      (clk),
      .clk_late (clk_late),
      .rst_n    (rst_n),
      .d        (in_data[b]),
      .load     (load),
      .restore  (restore),
      .main_q   (main_word[b]),
      .shadow_q (shadow_word[b]),
      .mismatch (bit_mismatch[b])
    );
  end

  assign any_mismatch = |bit_mismatch;

  razor_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .any_mismatch (any_mismatch),
    .err_now      (err_now),
    .load         (load),
    .restore      (restore),
    .main_valid   (main_valid),
    .out_valid    (out_valid)
  );

  err_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .hit   (err_now),
    .count (err_count)
  );

  assign out_data = main_word;
  assign err_flag = err_now;
  assign stall_up = err_now;

endmodule

// File: rtl/tmerr_reg_bank_chk.sv
module tmerr_reg_bank_chk #(
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [W-1:0]     in_data,
  input logic             stall_up,
  input logic             out_valid,
  input logic [W-1:0]     out_data,
  input logic             err_flag,
  input logic [CNT_W-1:0] err_count,
  input logic             main_valid,
  input logic [W-1:0]     shadow_word
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  AST_CAPTURE_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    !stall_up |=> out_data == $past(in_data)); // R2
  AST_ERR_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !main_valid |-> !err_flag); // R4
  AST_ERR_HIDES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |-> (!out_valid && stall_up)); // R5
  AST_RESTORE_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> (out_valid && out_data == $past(shadow_word))); // R6
  AST_STALL_TAKES_NOTHING: assert property (@(posedge clk) disable iff (!rst_n)
    stall_up |=> !stall_up && out_valid); // R7
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> !err_flag); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !err_flag |=> $stable(err_count)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && err_count != CMAX) |=> err_count == $past(err_count) + 1'b1); // R9
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (err_count == CMAX) |=> (err_count == CMAX)); // R9

endmodule

bind tmerr_reg_bank tmerr_reg_bank_chk #(.W(W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_data     (in_data),
  .stall_up    (stall_up),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .err_flag    (err_flag),
  .err_count   (err_count),
  .main_valid  (main_valid),
  .shadow_word (shadow_word)
);

// File: tb/test_tmerr_reg_bank.sv
`timescale 1ns/1ps
module test_tmerr_reg_bank;

  localparam int unsigned W     = 8;
  localparam int unsigned CNT_W = 4;
  localparam int unsigned CMAX  = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             clk_late = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [W-1:0]     in_data = '0;
  logic             stall_up;
  logic             out_valid;
  logic [W-1:0]     out_data;
  logic             err_flag;
  logic [CNT_W-1:0] err_count;

  int checks = 0;
  int fails  = 0;
  int model_cnt = 0;
  bit done = 1'b0;

  tmerr_reg_bank #(.W(W), .CNT_W(CNT_W)) i_tmerr_reg_bank (
    .clk(clk), .clk_late(clk_late), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .stall_up(stall_up),
    .out_valid(out_valid), .out_data(out_data), .err_flag(err_flag),
    .err_count(err_count)
  );

  // 125 MHz main clock; late clock trails by 2 ns.
  initial begin
    forever begin
      clk = 1'b1; #2; clk_late = 1'b1; #2;
      clk = 1'b0; #2; clk_late = 1'b0; #2;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Entered 6 ns after a clk edge. Presents one operation; if late, the
  // captured value is val^mask and the settled value val arrives before
  // the late edge.
  task automatic send(input logic [W-1:0] val, input bit vld, input bit late,
                      input logic [W-1:0] mask);
    bit exp_err;
    in_valid = vld;
    in_data  = late ? (val ^ mask) : val;
    @(posedge clk); #1;
    in_data = val;
    #4; // +5 ns: after late edge
    exp_err = vld && late;
    chk(exp_err ? "R3 err_flag" : "R4 err_flag", 32'(err_flag), 32'(exp_err));
    chk("R5 stall_up", 32'(stall_up), 32'(exp_err));
    chk("R5 out_valid", 32'(out_valid), 32'(vld && !late));
    if (vld && !late) chk("R2 out_data", 32'(out_data), 32'(val));
    chk("R9 err_count", 32'(err_count), 32'(model_cnt));
    #1; // +6 ns
    if (exp_err) begin
      if (model_cnt < CMAX) model_cnt++;
      in_valid = 1'b1;
      in_data  = ~val; // offered while stalled; must be ignored
      @(posedge clk); #5;
      chk("R6 out_valid", 32'(out_valid), 32'd1);
      chk("R7 out_data", 32'(out_data), 32'(val));
      chk("R8 err_flag", 32'(err_flag), 32'd0);
      chk("R8 stall_up", 32'(stall_up), 32'd0);
      chk("R9 err_count", 32'(err_count), 32'(model_cnt));
      #1;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    chk("R1 out_valid", 32'(out_valid), 32'd0);
    chk("R1 err_flag", 32'(err_flag), 32'd0);
    chk("R1 stall_up", 32'(stall_up), 32'd0);
    chk("R1 err_count", 32'(err_count), 32'd0);
    #1; rst_n = 1'b1;
    @(posedge clk); #5;
    chk("R1 out_valid after release", 32'(out_valid), 32'd0);
    chk("R1 err_flag after release", 32'(err_flag), 32'd0);
    #1;
    // Sweep every data value; vary validity, lateness and glitch shape.
    for (int v = 0; v < (1 << W); v++) begin
      logic [W-1:0] m;
      m = (v % 11 == 0) ? '1 : W'(1 << (v % W));
      send(W'(v), (v % 7) != 5, (v % 3) == 1, m);
    end
    // Back-to-back late operations, each bit alone.
    for (int b = 0; b < W; b++) send(W'(8'h5A + b), 1'b1, 1'b1, W'(1 << b));
    chk("R9 saturated", 32'(err_count), CMAX);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule